// File: doc/BRIEF.md
# Halfword Zero-Extend Decode Unit

This unit recognises one bit-manipulation operation: it clears every bit of a source register above bit 15 and sends the result to a destination register. The core it serves runs with either a 32-bit or a 64-bit register width, chosen by a mode input. The bit pattern for the operation differs between the two widths. The pattern that belongs to the other width is reported as illegal and is never executed.

The unit takes a 32-bit instruction word, the width mode, an extension-enable bit and the source operand. It returns a hit flag, an illegal flag, the destination and source register indices, and a 64-bit result. When a word matches neither pattern, both flags stay low so that a neighbouring decoder can claim it. The decode logic is combinational. A parameter adds one register stage at the outputs, and that stage is on by default.

Top module: `hzext_unit`

## Requirements
- R1: In 32-bit mode (`wide_mode_i`=0) with `ext_en_i`=1, a word with bits[31:25]=0000100, bits[24:20]=00000, bits[14:12]=100 and bits[6:0]=0110011 sets `hit_o`=1 and `illegal_o`=0.
- R2: In 64-bit mode (`wide_mode_i`=1) with `ext_en_i`=1, a word with the same upper fields and bits[6:0]=0111011 sets `hit_o`=1 and `illegal_o`=0.
- R3: In 64-bit mode, a word that carries the 32-bit pattern (opcode 0110011) sets `illegal_o`=1 and `hit_o`=0, and `result_o` is zero. This holds whatever the value of `ext_en_i`.
- R4: In 32-bit mode, a word that carries the 64-bit pattern (opcode 0111011) sets `illegal_o`=1 and `hit_o`=0.
- R5: On a hit, `result_o` equals the source operand bits [15:0], and bits [63:16] are zero. This holds in both modes.
- R6: With `ext_en_i`=0, a word that matches the pattern for the current mode sets `illegal_o`=1 and `hit_o`=0.
- R7: On a hit, `dst_idx_o` equals word bits [11:7] and `src_idx_o` equals word bits [19:15]. When there is no hit, both are zero.
- R8: A word whose funct3, rs2 or funct7 field differs from the pattern gives `hit_o`=0, `illegal_o`=0 and zero on all other outputs.
- R9: `hit_o` and `illegal_o` are never high in the same cycle.
- R10: With `REG_OUT`=1, the outputs show the decode of the inputs sampled at the previous rising clock edge. An active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset |
| insn_i | input | 32 | Instruction word |
| wide_mode_i | input | 1 | 1 = 64-bit register width, 0 = 32-bit |
| ext_en_i | input | 1 | Bit-manipulation extension enable |
| src_val_i | input | 64 | Source register value |
| hit_o | output | 1 | Operation recognised and executed |
| illegal_o | output | 1 | Illegal-instruction indication |
| dst_idx_o | output | 5 | Destination register index |
| src_idx_o | output | 5 | Source register index |
| result_o | output | 64 | Zero-extended halfword result |

## Verification
The assertions check on every cycle that:
- the two flags are never both high;
- the upper result bits are always zero;
- the outputs are quiet whenever there is no hit;
- with the register stage on, a hit carries the low halfword and the destination index of the previous cycle's inputs;
- an illegal flag traces back to one of the two opcodes.

Some behaviours only the bench scenarios can show. These are the choice between the two patterns in each mode, the effect of the enable bit, the rejection of near-miss field values, and the one-cycle latency and reset clearing at the ports.

// File: rtl/hzext_pkg.sv
package hzext_pkg;
    localparam int XLEN     = 64;
    localparam int HALF_W   = 16;
    localparam int REGIDX_W = 5;
    localparam int INSN_W   = 32;

    localparam logic [6:0] F7_ZEXT   = 7'b0000100;
    localparam logic [2:0] F3_ZEXT   = 3'b100;
    localparam logic [6:0] OP_NARROW = 7'b0110011;
    localparam logic [6:0] OP_WIDE   = 7'b0111011;

    typedef struct packed {
        logic                hit;
        logic                illegal;
        logic [REGIDX_W-1:0] rd;
        logic [REGIDX_W-1:0] rs1;
        logic [XLEN-1:0]     res;
    } dec_out_t;
endpackage

// File: rtl/hzext_match.sv
module hzext_match
    import hzext_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    input  logic              wide_mode_i,
    input  logic              ext_en_i,
    output logic              hit_o,
    output logic              illegal_o
);
    logic fields_ok;
    logic is_narrow;
    logic is_wide;
    logic native;
    logic foreign;

    always_comb begin
        fields_ok = (insn_i[31:25] == F7_ZEXT) && (insn_i[24:20] == '0)
                    && (insn_i[14:12] == F3_ZEXT);
        is_narrow = fields_ok && (insn_i[6:0] == OP_NARROW);
        is_wide   = fields_ok && (insn_i[6:0] == OP_WIDE);
        native    = wide_mode_i ? is_wide : is_narrow;
        foreign   = wide_mode_i ? is_narrow : is_wide;
        hit_o     = native && ext_en_i;
        illegal_o = foreign || (native && !ext_en_i);
    end

    always_comb begin
        assert (!(hit_o && illegal_o) || $isunknown(insn_i))
            else $error("p_flag_excl_comb_r9");
    end
endmodule

// File: rtl/hzext_format.sv
module hzext_format
    import hzext_pkg::*;
(
    input  logic              hit_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [XLEN-1:0]   src_val_i,
    output logic [REGIDX_W-1:0] rd_o,
    output logic [REGIDX_W-1:0] rs1_o,
    output logic [XLEN-1:0]   res_o
);
    localparam int UPPER_W = XLEN - HALF_W;

    always_comb begin
        rd_o  = '0;
        rs1_o = '0;
        res_o = '0;
        if (hit_i) begin
            rd_o  = insn_i[11:7];
            rs1_o = insn_i[19:15];
            res_o = {{UPPER_W{1'b0}}, src_val_i[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/hzext_stage.sv
module hzext_stage
    import hzext_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  dec_out_t in_i,
    output dec_out_t out_o
);
    dec_out_t out_d;

    always_comb begin
        out_d = in_i;
    end

    generate
        if (REG_OUT) begin : g_reg
            dec_out_t out_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
            assign out_o = out_q;
        end else begin : g_comb
            assign out_o = out_d;
        end
    endgenerate

    p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_o.hit && out_o.illegal));
    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_o.res[XLEN-1:HALF_W] == '0);
    p_quiet_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_o.hit |-> (out_o.res == '0 && out_o.rd == '0 && out_o.rs1 == '0));
endmodule

// File: rtl/hzext_unit.sv
module hzext_unit
    import hzext_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSN_W-1:0]   insn_i,
    input  logic                wide_mode_i,
    input  logic                ext_en_i,
    input  logic [XLEN-1:0]     src_val_i,
    output logic                hit_o,
    output logic                illegal_o,
    output logic [REGIDX_W-1:0] dst_idx_o,
    output logic [REGIDX_W-1:0] src_idx_o,
    output logic [XLEN-1:0]     result_o
);
    logic     hit_c;
    logic     illegal_c;
    dec_out_t dec_c;
    dec_out_t dec_s;

    hzext_match u_match (
        .insn_i      (insn_i),
        .wide_mode_i (wide_mode_i),
        .ext_en_i    (ext_en_i),
        .hit_o       (hit_c),
        .illegal_o   (illegal_c)
    );

    hzext_format u_format (
        .hit_i     (hit_c),
        .insn_i    (insn_i),
        .src_val_i (src_val_i),
        .rd_o      (dec_c.rd),
        .rs1_o     (dec_c.rs1),
        .res_o     (dec_c.res)
    );

    assign dec_c.hit     = hit_c;
    assign dec_c.illegal = illegal_c;

    hzext_stage #(.REG_OUT(REG_OUT)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (dec_c),
        .out_o (dec_s)
    );

    assign hit_o     = dec_s.hit;
    assign illegal_o = dec_s.illegal;
    assign dst_idx_o = dec_s.rd;
    assign src_idx_o = dec_s.rs1;
    assign result_o  = dec_s.res;

    generate
        if (REG_OUT) begin : g_chk
            p_result_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> result_o[HALF_W-1:0] == $past(src_val_i[HALF_W-1:0]));
            p_dst_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
                hit_o |-> dst_idx_o == $past(insn_i[11:7]));
            p_illegal_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
                illegal_o |-> ($past(insn_i[6:0]) == OP_NARROW
                               || $past(insn_i[6:0]) == OP_WIDE));
        end
    endgenerate
endmodule

// File: tb/hzext_unit_tb.sv
module hzext_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    typedef struct packed {
        logic [31:0] insn;
        logic        wide;
        logic        en;
        logic [63:0] src;
        logic        hit;
        logic        ill;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [63:0] res;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        // R1 R5 R7: narrow pattern in 32-bit mode
        '{ {7'h04,5'd0,5'd10,3'd4,5'd3,7'h33}, 1'b0, 1'b1, 64'hDEAD_BEEF_CAFE_1234,
           1'b1, 1'b0, 5'd3, 5'd10, 64'h1234, 4'd1 },
        // R2 R5: wide pattern in 64-bit mode
        '{ {7'h04,5'd0,5'd1,3'd4,5'd31,7'h3B}, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF,
           1'b1, 1'b0, 5'd31, 5'd1, 64'hFFFF, 4'd2 },
        // R3: narrow pattern in 64-bit mode
        '{ {7'h04,5'd0,5'd5,3'd4,5'd6,7'h33}, 1'b1, 1'b1, 64'h1111_2222_3333_4444,
           1'b0, 1'b1, 5'd0, 5'd0, 64'h0, 4'd3 },
        // R4: wide pattern in 32-bit mode
        '{ {7'h04,5'd0,5'd5,3'd4,5'd6,7'h3B}, 1'b0, 1'b1, 64'h1111_2222_3333_4444,
           1'b0, 1'b1, 5'd0, 5'd0, 64'h0, 4'd4 },
        // R6: extension disabled, 32-bit
        '{ {7'h04,5'd0,5'd7,3'd4,5'd8,7'h33}, 1'b0, 1'b0, 64'hABCD,
           1'b0, 1'b1, 5'd0, 5'd0, 64'h0, 4'd6 },
        // R6: extension disabled, 64-bit
        '{ {7'h04,5'd0,5'd7,3'd4,5'd8,7'h3B}, 1'b1, 1'b0, 64'hABCD,
           1'b0, 1'b1, 5'd0, 5'd0, 64'h0, 4'd6 },
        // R8: funct3 differs
        '{ {7'h04,5'd0,5'd7,3'd7,5'd8,7'h33}, 1'b0, 1'b1, 64'hABCD,
           1'b0, 1'b0, 5'd0, 5'd0, 64'h0, 4'd8 },
        // R8: rs2 nonzero
        '{ {7'h04,5'd1,5'd7,3'd4,5'd8,7'h3B}, 1'b1, 1'b1, 64'hABCD,
           1'b0, 1'b0, 5'd0, 5'd0, 64'h0, 4'd8 },
        // R8: funct7 differs
        '{ {7'h24,5'd0,5'd7,3'd4,5'd8,7'h33}, 1'b0, 1'b1, 64'hABCD,
           1'b0, 1'b0, 5'd0, 5'd0, 64'h0, 4'd8 },
        // R3: foreign pattern with extension off is still illegal
        '{ {7'h04,5'd0,5'd9,3'd4,5'd2,7'h33}, 1'b1, 1'b0, 64'h5555,
           1'b0, 1'b1, 5'd0, 5'd0, 64'h0, 4'd3 },
        // R5 R7: sign bit of halfword not propagated, index zero
        '{ {7'h04,5'd0,5'd0,3'd4,5'd0,7'h33}, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_8000,
           1'b1, 1'b0, 5'd0, 5'd0, 64'h8000, 4'd5 }
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = '0;
    logic        wide_mode_i = 1'b0;
    logic        ext_en_i = 1'b0;
    logic [63:0] src_val_i = '0;
    logic        hit_o, illegal_o;
    logic [4:0]  dst_idx_o, src_idx_o;
    logic [63:0] result_o;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hzext_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .wide_mode_i(wide_mode_i),
        .ext_en_i(ext_en_i), .src_val_i(src_val_i), .hit_o(hit_o),
        .illegal_o(illegal_o), .dst_idx_o(dst_idx_o), .src_idx_o(src_idx_o),
        .result_o(result_o)
    );

    task automatic check_all(input string tag, input logic h, input logic il,
                             input logic [4:0] rd, input logic [4:0] rs,
                             input logic [63:0] res);
        n_checks++;
        if (hit_o !== h || illegal_o !== il || dst_idx_o !== rd
            || src_idx_o !== rs || result_o !== res) begin
            n_errors++;
            $display("FAIL %s: got hit=%b ill=%b rd=%0d rs1=%0d res=%h, exp hit=%b ill=%b rd=%0d rs1=%0d res=%h",
                     tag, hit_o, illegal_o, dst_idx_o, src_idx_o, result_o,
                     h, il, rd, rs, res);
        end
    endtask

    task automatic drive(input logic [31:0] w, input logic wd, input logic en,
                         input logic [63:0] s);
        insn_i = w; wide_mode_i = wd; ext_en_i = en; src_val_i = s;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R10 reset state", 0, 0, 0, 0, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VECS[i].insn, VECS[i].wide, VECS[i].en, VECS[i].src);
            @(negedge clk);
            check_all($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].hit,
                      VECS[i].ill, VECS[i].rd, VECS[i].rs1, VECS[i].res);
        end

        // R10: one-cycle latency, old value held until the edge
        @(negedge clk);
        drive({7'h04,5'd0,5'd12,3'd4,5'd20,7'h3B}, 1'b1, 1'b1, 64'h0000_0000_0001_BEEF);
        @(negedge clk);
        check_all("R10 hit after one edge", 1, 0, 5'd20, 5'd12, 64'hBEEF);
        drive(32'h0000_0013, 1'b1, 1'b1, 64'h0);
        #1;
        check_all("R10 held before edge", 1, 0, 5'd20, 5'd12, 64'hBEEF);
        @(negedge clk);
        check_all("R8 R10 unrelated word after edge", 0, 0, 0, 0, 0);

        // R10: reset clears a pending hit
        drive({7'h04,5'd0,5'd4,3'd4,5'd9,7'h33}, 1'b0, 1'b1, 64'h7777);
        @(negedge clk);
        check_all("R1 before reset", 1, 0, 5'd9, 5'd4, 64'h7777);
        rst_n = 1'b0;
        #1;
        check_all("R10 reset clears outputs", 0, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: got timeout, exp completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule